// File: doc/BRIEF.md
# Dual-Channel PWM Slice

This block is one slice of a pulse-width modulator. A 16-bit counter steps forward on every clock cycle where an external clock-enable strobe is high and the slice is enabled. Two channels compare their own threshold against the counter and drive one output each. The counter runs either as a sawtooth, returning to zero after the programmed top value, or as a triangle, rising to top and falling back to zero. The triangle mode keeps each pulse centred within the period, and its period is twice as long as the sawtooth's.

Software controls the slice through a write-only port with a write enable, a 3-bit address and a 17-bit data word. The live counter value is always visible on an output and can be overwritten at any time. A sticky flag records each wrap of the counter and is cleared by software. Register map (address: content): 0 control (bit 0 enable, bit 1 triangle mode, bit 2 invert channel A, bit 3 invert channel B); 1 top value (bits 15:0); 2 channel A threshold (bits 16:0); 3 channel B threshold (bits 16:0); 4 counter load (bits 15:0); 5 flag clear (bit 0). Addresses 6 and 7 have no effect.

Top module: `pwm_slice`

## Requirements
- R1: After reset the counter is 0, both outputs are low, the wrap flag is clear, the slice is disabled in sawtooth mode with no inversion, both thresholds are 0 and the top value is 0xFFFF.
- R2: The counter changes only on a cycle where the enable bit and the tick input are both high; on any other cycle without a load it holds its value.
- R3: In sawtooth mode an advance from a count below top adds one, and an advance at count equal to top returns the counter to 0 and sets the wrap flag in the same cycle.
- R4: In triangle mode the counter rises by one per advance up to top, holds at top for one advance while turning downward, falls by one per advance to 0, and holds at 0 for one advance while turning upward and setting the wrap flag, so one period lasts 2*(top+1) advances.
- R5: Each output equals (threshold > counter) XOR that channel's invert bit, and the two channels are independent of each other.
- R6: A threshold of 0 holds the output at its inverted level (low when not inverted), and a threshold of top+1 or more holds it at the opposite level; thresholds are 17 bits wide so top+1 can be written when top is 0xFFFF.
- R7: A write to the counter-load address sets the counter on the next cycle, takes priority over an advance in that cycle, and leaves the triangle direction unchanged.
- R8: The wrap flag stays set until a write to the flag-clear address with bit 0 high clears it; a write with bit 0 low has no effect, and a wrap in the same cycle as a clear leaves the flag set.
- R9: Writes to the top and threshold registers take effect on the cycle after the write, with no buffering until the end of a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Clock-enable strobe for the counter |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 17 | Register write data |
| count_o | output | 16 | Current counter value |
| out_a_o | output | 1 | Channel A output |
| out_b_o | output | 1 | Channel B output |
| wrap_flag_o | output | 1 | Sticky wrap flag |

## Verification
A register write or an advancing tick that is present at a clock edge shows up on count_o and wrap_flag_o right after that edge, since the counter, the flag and the registers are one flop stage deep. The outputs are combinational from those flops, so they change in the same cycle as the counter or the threshold that drives them. The bench drives every input one time unit after a rising edge and samples one time unit after the following rising edge, which places each check in exactly the cycle where the result is due.

// File: rtl/pwm_slice_pkg.sv
package pwm_slice_pkg;

    localparam int NCH = 2;

    typedef enum logic [2:0] {
        ADDR_CTRL  = 3'd0,
        ADDR_TOP   = 3'd1,
        ADDR_CMPA  = 3'd2,
        ADDR_CMPB  = 3'd3,
        ADDR_LOAD  = 3'd4,
        ADDR_FLAG  = 3'd5
    } reg_addr_e;

    // bit 0 enable, bit 1 triangle, bit 2 invert A, bit 3 invert B
    typedef struct packed {
        logic inv_b;
        logic inv_a;
        logic tri_mode;
        logic enable;
    } ctrl_t;

endpackage

// File: rtl/pwm_slice_regs.sv
module pwm_slice_regs
    import pwm_slice_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en_i,
    input  logic [2:0]                     wr_addr_i,
    input  logic [CNT_W:0]                 wr_data_i,
    input  logic                           wrap_i,
    output ctrl_t                          ctrl_o,
    output logic [CNT_W-1:0]               top_o,
    output logic [NCH-1:0][CNT_W:0]        cmp_o,
    output logic                           load_o,
    output logic [CNT_W-1:0]               load_val_o,
    output logic                           flag_o
);

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        ctrl_t                    ctrl;
        logic [CNT_W-1:0]         top;
        logic [NCH-1:0][CNT_W:0]  cmp;
        logic                     flag;
    } rstate_t;

    rstate_t st_d, st_q;
    logic    clear_req;

    assign clear_req = wr_en_i && (wr_addr_i == ADDR_FLAG) && wr_data_i[0];

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            case (wr_addr_i)
                ADDR_CTRL: st_d.ctrl = ctrl_t'(wr_data_i[CTRL_W-1:0]);
                ADDR_TOP:  st_d.top  = wr_data_i[CNT_W-1:0];
                default:   ;
            endcase
            for (int ch = 0; ch < NCH; ch++) begin
                if (wr_addr_i == (ADDR_CMPA + 3'(ch))) begin
                    st_d.cmp[ch] = wr_data_i;
                end
            end
        end
        if (clear_req) begin
            st_d.flag = 1'b0;
        end
        if (wrap_i) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl <= '0;
            st_q.top  <= '1;
            st_q.cmp  <= '0;
            st_q.flag <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o     = st_q.ctrl;
    assign top_o      = st_q.top;
    assign cmp_o      = st_q.cmp;
    assign flag_o     = st_q.flag;
    assign load_o     = wr_en_i && (wr_addr_i == ADDR_LOAD);
    assign load_val_o = wr_data_i[CNT_W-1:0];

    // R8
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_i |=> flag_o);

    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_req && !wrap_i) |=> !flag_o);

    // R9
    top_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == ADDR_TOP) |=> top_o == $past(wr_data_i[CNT_W-1:0]));

endmodule

// File: rtl/pwm_slice_counter.sv
module pwm_slice_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    input  logic             tri_i,
    input  logic [CNT_W-1:0] top_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             down;
    } cstate_t;

    cstate_t st_d, st_q;
    logic    wrap_d;

    always_comb begin
        st_d   = st_q;
        wrap_d = 1'b0;
        if (load_i) begin
            st_d.cnt = load_val_i;
        end else if (adv_i) begin
            if (!tri_i) begin
                st_d.down = 1'b0;
                if (st_q.cnt == top_i) begin
                    st_d.cnt = '0;
                    wrap_d   = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + ONE;
                end
            end else if (!st_q.down) begin
                if (st_q.cnt >= top_i) begin
                    st_d.down = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + ONE;
                end
            end else begin
                if (st_q.cnt == '0) begin
                    st_d.down = 1'b0;
                    wrap_d    = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - ONE;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign wrap_o = wrap_d;

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !load_i) |=> $stable(cnt_o));

    // R2
    saw_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !tri_i && !load_i && cnt_o != top_i) |=> cnt_o == $past(cnt_o) + ONE);

    // R3
    saw_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !tri_i && !load_i && cnt_o == top_i) |=> cnt_o == '0);

    // R4
    tri_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && tri_i && !load_i && cnt_o <= top_i) |=> (cnt_o <= top_i || !$stable(top_i)));

    // R7
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> cnt_o == $past(load_val_i));

endmodule

// File: rtl/pwm_slice_cmp.sv
module pwm_slice_cmp #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W:0]   thr_i,
    input  logic             inv_i,
    output logic             out_o
);

    logic raw;

    always_comb begin
        raw   = (thr_i > {1'b0, cnt_i});
        out_o = raw ^ inv_i;
    end

    // R6
    zero_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_i == '0) |-> (out_o == inv_i));

endmodule

// File: rtl/pwm_slice.sv
module pwm_slice
    import pwm_slice_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             wr_en_i,
    input  logic [2:0]       wr_addr_i,
    input  logic [CNT_W:0]   wr_data_i,
    output logic [CNT_W-1:0] count_o,
    output logic             out_a_o,
    output logic             out_b_o,
    output logic             wrap_flag_o
);

    ctrl_t                    ctrl;
    logic [CNT_W-1:0]         top;
    logic [NCH-1:0][CNT_W:0]  cmp;
    logic                     load;
    logic [CNT_W-1:0]         load_val;
    logic                     wrap;
    logic [CNT_W-1:0]         cnt;
    logic [NCH-1:0]           inv;
    logic [NCH-1:0]           pwm;

    pwm_slice_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .wrap_i     (wrap),
        .ctrl_o     (ctrl),
        .top_o      (top),
        .cmp_o      (cmp),
        .load_o     (load),
        .load_val_o (load_val),
        .flag_o     (wrap_flag_o)
    );

    pwm_slice_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv_i      (ctrl.enable && tick_i),
        .tri_i      (ctrl.tri_mode),
        .top_i      (top),
        .load_i     (load),
        .load_val_i (load_val),
        .cnt_o      (cnt),
        .wrap_o     (wrap)
    );

    assign inv = {ctrl.inv_b, ctrl.inv_a};

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        pwm_slice_cmp #(.CNT_W(CNT_W)) u_cmp (
            .clk   (clk),
            .rst_n (rst_n),
            .cnt_i (cnt),
            .thr_i (cmp[c]),
            .inv_i (inv[c]),
            .out_o (pwm[c])
        );
    end

    assign count_o = cnt;
    assign out_a_o = pwm[0];
    assign out_b_o = pwm[1];

    // R6
    full_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp[0] > {1'b0, top} && cnt <= top) |-> (out_a_o == !ctrl.inv_a));

    // R2
    disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.enable && !load) |=> $stable(count_o));

endmodule

// File: tb/pwm_slice_test.sv
module pwm_slice_test;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_TOP  = 3'd1;
    localparam logic [2:0] A_CMPA = 3'd2;
    localparam logic [2:0] A_CMPB = 3'd3;
    localparam logic [2:0] A_LOAD = 3'd4;
    localparam logic [2:0] A_FLAG = 3'd5;
    localparam logic [16:0] C_EN   = 17'd1;
    localparam logic [16:0] C_TRI  = 17'd2;
    localparam logic [16:0] C_INVA = 17'd4;
    localparam logic [16:0] C_INVB = 17'd8;

    typedef struct packed {
        logic [15:0] top;
        logic [16:0] thr;
        logic [15:0] cnt;
        logic        inv;
        logic        exp;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{16'd100,   17'd50,      16'd49,     1'b0, 1'b1},
        '{16'd100,   17'd50,      16'd50,     1'b0, 1'b0},
        '{16'd100,   17'd50,      16'd51,     1'b0, 1'b0},
        '{16'd100,   17'd0,       16'd0,      1'b0, 1'b0},
        '{16'd100,   17'd101,     16'd100,    1'b0, 1'b1},
        '{16'd100,   17'd50,      16'd49,     1'b1, 1'b0},
        '{16'd100,   17'd0,       16'd0,      1'b1, 1'b1},
        '{16'hFFFF,  17'h10000,   16'hFFFF,   1'b0, 1'b1},
        '{16'd10,    17'd3,       16'd2,      1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [16:0] wr_data = '0;
    logic [15:0] count;
    logic        out_a, out_b, flag;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pwm_slice uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .wr_en_i     (wr_en),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .count_o     (count),
        .out_a_o     (out_a),
        .out_b_o     (out_b),
        .wrap_flag_o (flag)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [16:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        step();
        wr_en   = 1'b0;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        for (int i = 0; i < n; i++) step();
        tick = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        chk("R1 count", 32'(count), 32'd0);
        chk("R1 out_a", 32'(out_a), 32'd0);
        chk("R1 out_b", 32'(out_b), 32'd0);
        chk("R1 flag", 32'(flag), 32'd0);
        ticks(2);
        chk("R1 disabled after reset", 32'(count), 32'd0);
        // R1 default top 0xFFFF: wrap with flag at 0xFFFF
        wr(A_LOAD, 17'hFFFE);
        wr(A_CTRL, C_EN);
        ticks(1);
        chk("R1 count below default top", 32'(count), 32'hFFFF);
        chk("R1 no flag below top", 32'(flag), 32'd0);
        ticks(1);
        chk("R1 wrap at default top", 32'(count), 32'd0);
        chk("R1 flag at default top", 32'(flag), 32'd1);
        wr(A_FLAG, 17'd1);
        wr(A_CTRL, 17'd0);

        // R5 R6 vector table on channel A
        for (int v = 0; v < NV; v++) begin
            wr(A_TOP, 17'(VECS[v].top));
            wr(A_CMPA, VECS[v].thr);
            wr(A_LOAD, 17'(VECS[v].cnt));
            wr(A_CTRL, VECS[v].inv ? C_INVA : 17'd0);
            chk("R5/R6 vector out_a", 32'(out_a), 32'(VECS[v].exp));
        end

        // R5 channel independence
        wr(A_TOP, 17'd100);
        wr(A_LOAD, 17'd20);
        wr(A_CMPA, 17'd30);
        wr(A_CMPB, 17'd10);
        wr(A_CTRL, C_INVB);
        chk("R5 out_a", 32'(out_a), 32'd1);
        chk("R5 out_b inverted", 32'(out_b), 32'd1);
        wr(A_CTRL, 17'd0);
        chk("R5 out_b plain", 32'(out_b), 32'd0);
        chk("R5 out_a unaffected", 32'(out_a), 32'd1);

        // R9 threshold write effective next cycle
        wr(A_CMPA, 17'd15);
        chk("R9 new threshold", 32'(out_a), 32'd0);

        // R2 gating
        wr(A_TOP, 17'd1000);
        wr(A_LOAD, 17'd0);
        ticks(3);
        chk("R2 disabled with tick", 32'(count), 32'd0);
        wr(A_CTRL, C_EN);
        repeat (3) step();
        chk("R2 enabled without tick", 32'(count), 32'd0);
        ticks(5);
        chk("R2 five advances", 32'(count), 32'd5);
        for (int i = 0; i < 4; i++) begin
            tick = i[0];
            step();
        end
        tick = 1'b0;
        chk("R2 alternating tick", 32'(count), 32'd7);

        // R3 sawtooth wrap
        wr(A_TOP, 17'd3);
        wr(A_LOAD, 17'd2);
        wr(A_FLAG, 17'd1);
        ticks(1);
        chk("R3 reach top", 32'(count), 32'd3);
        chk("R3 no flag at top", 32'(flag), 32'd0);
        ticks(1);
        chk("R3 wrap to zero", 32'(count), 32'd0);
        chk("R3 flag set", 32'(flag), 32'd1);
        ticks(1);
        chk("R8 flag sticky", 32'(flag), 32'd1);

        // R8 clear semantics
        wr(A_FLAG, 17'd0);
        chk("R8 write zero ignored", 32'(flag), 32'd1);
        wr(A_FLAG, 17'd1);
        chk("R8 cleared", 32'(flag), 32'd0);
        wr(A_LOAD, 17'd3);
        tick = 1'b1;
        wr(A_FLAG, 17'd1);
        tick = 1'b0;
        chk("R8 wrap beats clear", 32'(flag), 32'd1);
        chk("R8 count wrapped", 32'(count), 32'd0);

        // R9 top change mid-count
        wr(A_FLAG, 17'd1);
        wr(A_TOP, 17'd100);
        wr(A_LOAD, 17'd5);
        wr(A_TOP, 17'd5);
        ticks(1);
        chk("R9 new top wraps", 32'(count), 32'd0);
        chk("R9 flag on new top", 32'(flag), 32'd1);

        // R4 triangle sequence with top 2
        wr(A_TOP, 17'd2);
        wr(A_LOAD, 17'd0);
        wr(A_FLAG, 17'd1);
        wr(A_CTRL, C_EN | C_TRI);
        begin
            int exp_seq [6] = '{1, 2, 2, 1, 0, 0};
            for (int i = 0; i < 6; i++) begin
                ticks(1);
                chk("R4 triangle count", 32'(count), 32'(exp_seq[i]));
                chk("R4 triangle flag", 32'(flag), (i == 5) ? 32'd1 : 32'd0);
            end
        end
        ticks(1);
        chk("R4 rising again", 32'(count), 32'd1);

        // R7 load during down-count keeps direction
        ticks(2);
        chk("R7 at top turning", 32'(count), 32'd2);
        tick = 1'b1;
        wr(A_LOAD, 17'd1);
        tick = 1'b0;
        chk("R7 load beats advance", 32'(count), 32'd1);
        ticks(1);
        chk("R7 direction kept", 32'(count), 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule